// File: doc/BRIEF.md
# Receiver Control and Status Register Slave on a Two-Wire Serial Bus

This block sits on a two-wire serial bus (I2C) and gives a host byte-wide access to the control and status registers of a data receiver. It responds to a 7-bit slave address made of a fixed pattern and one strap pin. A write transfer carries a sub-address byte followed by data bytes. A read is a combined transfer: the sub-address is set in a write phase, then a repeated start and a read phase return data bytes. In both directions the sub-address advances by one after every data byte.

The control registers are written at one sub-address and read back at another. Three bits of the second control register are action triggers. An action fires only when a write clears a bit that the previous write had set. The block keeps a sticky loss-of-lock flag and a sticky measurement-complete flag, each cleared by one of these triggers. It drives the loss-of-lock output either from the live lock state or from the sticky flag, and it can invert the loss-of-signal output.

SCL and SDA are resynchronised into the system clock with a two-flop stage before edges are detected. Each phase of SCL must therefore last several system clocks. The block's data output is an active-high pull-down enable (`sda_oe_o`); the pad itself sits outside the block.

Top module: `rx_ctrl_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1, `strap_i`, 0, 0, 0, 0, 0 (MSB first). Bit 0 of the address byte selects write (0) or read (1).
- R2: In a write transfer the block acknowledges the sub-address and every data byte. The first data byte goes to the sub-address, and each further byte goes to the next sub-address (8-bit wrap).
- R3: After a repeated start with a read address, the block returns the byte at the current sub-address and then the following sub-addresses while the master acknowledges. A master not-acknowledge ends the read.
- R4: Control register A is written at 0x08 and read at 0x05, and drives `ctrl_a_o`. Control register B is written at 0x09 and read at 0x06. Control register C is written at 0x11. Writes to 0x05 and 0x06 change nothing.
- R5: A read from any sub-address other than 0x04, 0x05 and 0x06 returns 0x00. A write to any sub-address other than 0x08, 0x09 and 0x11 is discarded.
- R6: Reading 0x04 returns `los_raw_i` in bit 5, the sticky loss-of-lock flag in bit 4, `lol_live_i` (1 = acquiring) in bit 3 and the sticky measurement-complete flag in bit 2; all other bits read 0. The sticky loss-of-lock flag sets in the cycle after `lol_live_i` is high, and the measurement flag sets after a pulse on `meas_done_i`.
- R7: Writing B with bit 6 at 0 when its previous value had bit 6 at 1 clears the sticky loss-of-lock flag. The same sequence on bit 3 clears the measurement flag. The same sequence on bit 5 gives a one-cycle pulse on `freq_acq_o`. Writing 0 over 0 does nothing.
- R8: When bit 7 of B is 0, `lol_o` follows `lol_live_i`. When bit 7 is 1, `lol_o` shows the sticky flag and holds until a write changes it.
- R9: When bit 2 of C is 1, `los_o` is the inverse of `los_raw_i`. Otherwise `los_o` equals `los_raw_i`.
- R10: After a non-matching address, the block does not drive SDA and ignores all further bytes until the next START or STOP.
- R11: After reset the control registers are 0, `sda_oe_o`, `freq_acq_o` and `lol_o` are 0, and the bus state is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 1 | Strap that sets address bit 5 |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| los_raw_i | input | 1 | Loss of signal from the receiver, 1 = lost |
| lol_live_i | input | 1 | Live lock state, 1 = acquiring |
| meas_done_i | input | 1 | Pulse when a rate measurement completes |
| lol_o | output | 1 | Loss-of-lock indication |
| los_o | output | 1 | Loss-of-signal indication with selectable polarity |
| freq_acq_o | output | 1 | One-cycle request to start frequency acquisition |
| ctrl_a_o | output | 8 | Contents of control register A |

## Verification
The case hardest to reach from the ports is a transfer to a foreign address. It must leave SDA untouched and change no register, even when its later bytes look exactly like a valid sub-address and data. To reach it, the stimulus flips the strap after a good write and resends the same bytes to the old address. It then reads back the register and counts every cycle in which the pull-down was enabled. The one-then-zero triggers need a similar sequence across two separate transfers. The random phase mixes writes to register B with status reads while the sticky flags are set, so trigger edges meet both set and clear flags.

// File: rtl/rx_ctrl_pkg.sv
`timescale 1ns/1ps
package rx_ctrl_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] ADR_STATUS = 8'h04;
    localparam logic [BYTE_W-1:0] ADR_A_RD   = 8'h05;
    localparam logic [BYTE_W-1:0] ADR_B_RD   = 8'h06;
    localparam logic [BYTE_W-1:0] ADR_A_WR   = 8'h08;
    localparam logic [BYTE_W-1:0] ADR_B_WR   = 8'h09;
    localparam logic [BYTE_W-1:0] ADR_C_WR   = 8'h11;

    // bit positions inside register B and C that other logic decodes
    localparam int B_STATIC  = 7;
    localparam int B_CLR_LOL = 6;
    localparam int B_ACQ     = 5;
    localparam int B_CLR_MEA = 3;
    localparam int C_LOS_INV = 2;

    typedef enum logic [3:0] {
        BS_IDLE,
        BS_ADDR,
        BS_ADDR_ACK,
        BS_SUB,
        BS_SUB_ACK,
        BS_WDATA,
        BS_WDATA_ACK,
        BS_RDATA,
        BS_RACK,
        BS_IGNORE
    } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_d, sda_d, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_slave_fsm.sv
`timescale 1ns/1ps
module i2c_slave_fsm
    import rx_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              strap_i,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] wr_data,
    output bus_state_t        state_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    bus_state_t state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg, tx;
    logic              rw_q, nack_q, byte_full, addr_hit;

    assign byte_full = (bit_cnt == FULL);
    assign addr_hit  = (shreg[7:1] == {1'b1, strap_i, 5'b00000});
    assign state_o   = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (stop_det)       state_d = BS_IDLE;
        else if (start_det) state_d = BS_ADDR;
        else begin
            unique case (state_q)
                BS_IDLE:      state_d = BS_IDLE;
                BS_ADDR:      if (scl_fall && byte_full) state_d = addr_hit ? BS_ADDR_ACK : BS_IGNORE;
                BS_ADDR_ACK:  if (scl_fall) state_d = rw_q ? BS_RDATA : BS_SUB;
                BS_SUB:       if (scl_fall && byte_full) state_d = BS_SUB_ACK;
                BS_SUB_ACK:   if (scl_fall) state_d = BS_WDATA;
                BS_WDATA:     if (scl_fall && byte_full) state_d = BS_WDATA_ACK;
                BS_WDATA_ACK: if (scl_fall) state_d = BS_WDATA;
                BS_RDATA:     if (scl_fall && byte_full) state_d = BS_RACK;
                BS_RACK:      if (scl_fall) state_d = nack_q ? BS_IGNORE : BS_RDATA;
                BS_IGNORE:    state_d = BS_IGNORE;
                default:      state_d = BS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            tx       <= '0;
            rw_q     <= 1'b0;
            nack_q   <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
            reg_addr <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state_q)
                    BS_ADDR, BS_SUB, BS_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall && byte_full) begin
                            bit_cnt <= '0;
                            if (state_q == BS_ADDR) begin
                                rw_q   <= shreg[0];
                                sda_oe <= addr_hit;
                            end else if (state_q == BS_SUB) begin
                                reg_addr <= shreg;
                                sda_oe   <= 1'b1;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= shreg;
                                sda_oe  <= 1'b1;
                            end
                        end
                    end
                    BS_ADDR_ACK: if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            tx       <= rd_data;
                            sda_oe   <= ~rd_data[BYTE_W-1];
                            reg_addr <= reg_addr + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    BS_SUB_ACK, BS_WDATA_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        if (state_q == BS_WDATA_ACK) reg_addr <= reg_addr + 1'b1;
                    end
                    BS_RDATA: begin
                        if (scl_rise && !byte_full) bit_cnt <= bit_cnt + 1'b1;
                        if (scl_fall) begin
                            if (byte_full) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end else begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    BS_RACK: begin
                        if (scl_rise) nack_q <= sda_s;
                        if (scl_fall && !nack_q) begin
                            tx       <= rd_data;
                            sda_oe   <= ~rd_data[BYTE_W-1];
                            reg_addr <= reg_addr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_csr_bank.sv
`timescale 1ns/1ps
module rx_csr_bank
    import rx_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              los_raw_i,
    input  logic              lol_live_i,
    input  logic              meas_done_i,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ctrl_a,
    output logic              lol_static,
    output logic              lol_sticky,
    output logic              lol_o,
    output logic              los_o,
    output logic              freq_acq_o
);
    logic [BYTE_W-1:0] ctrl_b, fall_bits;
    logic              los_inv, meas_sticky, wr_b;

    assign wr_b      = wr_en && (addr == ADR_B_WR);
    assign fall_bits = ctrl_b & ~wr_data;   // bits going 1 -> 0

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a      <= '0;
            ctrl_b      <= '0;
            los_inv     <= 1'b0;
            lol_sticky  <= 1'b0;
            meas_sticky <= 1'b0;
            freq_acq_o  <= 1'b0;
        end else begin
            if (wr_en && addr == ADR_A_WR) ctrl_a  <= wr_data;
            if (wr_b)                      ctrl_b  <= wr_data;
            if (wr_en && addr == ADR_C_WR) los_inv <= wr_data[C_LOS_INV];
            lol_sticky  <= lol_live_i  | (lol_sticky  & ~(wr_b & fall_bits[B_CLR_LOL]));
            meas_sticky <= meas_done_i | (meas_sticky & ~(wr_b & fall_bits[B_CLR_MEA]));
            freq_acq_o  <= wr_b & fall_bits[B_ACQ];
        end
    end

    assign lol_static = ctrl_b[B_STATIC];
    assign lol_o      = lol_static ? lol_sticky : lol_live_i;
    assign los_o      = los_raw_i ^ los_inv;

    always_comb begin
        case (addr)
            ADR_STATUS: rd_data = {2'b00, los_raw_i, lol_sticky, lol_live_i, meas_sticky, 2'b00};
            ADR_A_RD:   rd_data = ctrl_a;
            ADR_B_RD:   rd_data = ctrl_b;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rx_ctrl_i2c_slave.sv
`timescale 1ns/1ps
module rx_ctrl_i2c_slave
    import rx_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_i,
    output logic              sda_oe_o,
    input  logic              los_raw_i,
    input  logic              lol_live_i,
    input  logic              meas_done_i,
    output logic              lol_o,
    output logic              los_o,
    output logic              freq_acq_o,
    output logic [BYTE_W-1:0] ctrl_a_o
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, lol_static, lol_sticky;
    logic [BYTE_W-1:0] reg_addr, wr_data, rd_data;
    bus_state_t        bus_state;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_slave_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .strap_i(strap_i), .rd_data(rd_data), .sda_oe(sda_oe_o),
        .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
        .state_o(bus_state)
    );

    rx_csr_bank u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr),
        .wr_data(wr_data), .los_raw_i(los_raw_i), .lol_live_i(lol_live_i),
        .meas_done_i(meas_done_i), .rd_data(rd_data), .ctrl_a(ctrl_a_o),
        .lol_static(lol_static), .lol_sticky(lol_sticky), .lol_o(lol_o),
        .los_o(los_o), .freq_acq_o(freq_acq_o)
    );
endmodule

// File: rtl/rx_ctrl_i2c_slave_chk.sv
`timescale 1ns/1ps
module rx_ctrl_i2c_slave_chk
    import rx_ctrl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       freq_acq_o,
    input logic       lol_o,
    input logic       lol_live_i,
    input logic       wr_en,
    input logic       lol_static,
    input logic       lol_sticky,
    input bus_state_t bus_state
);
    a_r10_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == BS_IGNORE) |-> !sda_oe_o);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == BS_IDLE) |-> !sda_oe_o);

    a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    a_r7_acq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        freq_acq_o |=> !freq_acq_o);

    a_r8_static_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lol_static && lol_o && !wr_en) |=> lol_o);

    a_r6_sticky_sets: assert property (@(posedge clk) disable iff (!rst_n)
        lol_live_i |=> lol_sticky);
endmodule

bind rx_ctrl_i2c_slave rx_ctrl_i2c_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .freq_acq_o(freq_acq_o), .lol_o(lol_o), .lol_live_i(lol_live_i),
    .wr_en(wr_en), .lol_static(lol_static), .lol_sticky(lol_sticky),
    .bus_state(bus_state)
);

// File: tb/rx_ctrl_i2c_slave_test.sv
`timescale 1ns/1ps
module rx_ctrl_i2c_slave_test;
    localparam int Q = 8;   // clocks per quarter bit

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
    logic los_raw = 1'b0, lol_live = 1'b0, meas_done = 1'b0;
    logic sda_oe_o, lol_o, los_o, freq_acq_o;
    logic [7:0] ctrl_a_o;
    wire  sda_line = sda_m & ~sda_oe_o;

    rx_ctrl_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
        .sda_oe_o(sda_oe_o), .los_raw_i(los_raw), .lol_live_i(lol_live),
        .meas_done_i(meas_done), .lol_o(lol_o), .los_o(los_o),
        .freq_acq_o(freq_acq_o), .ctrl_a_o(ctrl_a_o)
    );

    int checks = 0, errors = 0, oe_cnt = 0, acq_cnt = 0;
    bit done = 0;
    logic [7:0] m_a = 0, m_b = 0;
    logic m_inv = 0, m_lol = 0, m_meas = 0;
    int m_acq = 0;

    always @(negedge clk) begin
        if (sda_oe_o) oe_cnt++;
        if (freq_acq_o) acq_cnt++;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic qw(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    // bench model of register behaviour
    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h04:   return {2'b00, los_raw, m_lol, lol_live, m_meas, 2'b00};
            8'h05:   return m_a;
            8'h06:   return m_b;
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_write(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h08: m_a = d;
            8'h09: begin
                if (m_b[6] && !d[6] && !lol_live) m_lol = 0;
                if (m_b[3] && !d[3]) m_meas = 0;
                if (m_b[5] && !d[5]) m_acq++;
                m_b = d;
            end
            8'h11: m_inv = d[2];
            default: ;
        endcase
    endtask

    task automatic bus_start();
        sda_m = 1; qw(); scl = 1; qw(); sda_m = 0; qw(); scl = 0; qw();
    endtask
    task automatic bus_stop();
        sda_m = 0; qw(); scl = 1; qw(); sda_m = 1; qw(2);
    endtask
    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw(); scl = 1; qw(2); scl = 0; qw();
        end
        sda_m = 1; qw(); scl = 1; qw(); ack = !sda_line; qw(); scl = 0; qw();
    endtask
    task automatic get_byte(input logic ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl = 1; qw(); b[i] = sda_line; qw(); scl = 0; qw();
        end
        sda_m = !ack; qw(); scl = 1; qw(2); scl = 0; qw(); sda_m = 1;
    endtask

    function automatic logic [7:0] dev(input logic s, input logic rd);
        return {1'b1, s, 5'b00000, rd};
    endfunction

    task automatic wr(input logic [7:0] sub, input int n, input logic [7:0] d0,
                      input logic [7:0] d1, output logic ok);
        logic a0, a1, a2, a3;
        bus_start();
        put_byte(dev(strap, 0), a0);
        put_byte(sub, a1);
        put_byte(d0, a2);
        a3 = 1;
        if (n > 1) put_byte(d1, a3);
        bus_stop();
        ok = a0 & a1 & a2 & a3;
        if (ok) begin
            m_write(sub, d0);
            if (n > 1) m_write(sub + 8'd1, d1);
        end
    endtask

    task automatic rd(input logic [7:0] sub, input int n, output logic [7:0] d0,
                      output logic [7:0] d1, output logic ok);
        logic a0, a1, a2;
        bus_start();
        put_byte(dev(strap, 0), a0);
        put_byte(sub, a1);
        sda_m = 1; qw(); scl = 1; qw(); sda_m = 0; qw(); scl = 0; qw();  // repeated start
        put_byte(dev(strap, 1), a2);
        d1 = 8'h00;
        if (n > 1) begin
            get_byte(1'b1, d0);
            get_byte(1'b0, d1);
        end else get_byte(1'b0, d0);
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] sub);
        logic [7:0] x, y;
        logic ok;
        rd(sub, 2, x, y, ok);
        chk({tag, " ack"}, {7'd0, ok}, 8'd1);
        chk({tag, " byte0"}, x, exp_rd(sub));
        chk({tag, " byte1"}, y, exp_rd(sub + 8'd1));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ok, a0, a1, a2;
        logic [7:0] sub, d0, d1;
        int unsigned seed_val;
        seed_val = $urandom(32'd91);
        repeat (10) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 sda_oe", {7'd0, sda_oe_o}, 8'd0);
        chk("R11 lol_o", {7'd0, lol_o}, 8'd0);
        chk("R11 acq", {7'd0, freq_acq_o}, 8'd0);
        chk("R11 ctrl_a", ctrl_a_o, 8'h00);
        rd_chk("R11 ctrl B reset", 8'h05);

        // R1 strap 0 -> address 0x40; R4 A write
        strap = 0;
        wr(8'h08, 1, 8'h5A, 8'h00, ok);
        chk("R1 ack strap0", {7'd0, ok}, 8'd1);
        chk("R4 ctrl_a_o", ctrl_a_o, 8'h5A);
        // R1/R10 strap 1, old address is foreign
        strap = 1;
        oe_cnt = 0;
        bus_start();
        put_byte(dev(1'b0, 0), a0);
        put_byte(8'h08, a1);
        put_byte(8'h00, a2);
        bus_stop();
        chk("R1 foreign nack", {7'd0, a0}, 8'd0);
        chk("R10 no drive", oe_cnt[7:0], 8'd0);
        chk("R10 ctrl_a kept", ctrl_a_o, 8'h5A);
        rd_chk("R4 read A at 0x05", 8'h05);

        // R2 multi-byte write, R3 multi-byte read
        wr(8'h08, 2, 8'hC3, 8'h80, ok);
        chk("R2 ack", {7'd0, ok}, 8'd1);
        rd_chk("R3 read A,B", 8'h05);

        // R8 static lol
        lol_live = 1; m_lol = 1; repeat (3) @(negedge clk);
        lol_live = 0; repeat (3) @(negedge clk);
        chk("R8 static holds", {7'd0, lol_o}, 8'd1);
        rd_chk("R6 status sticky", 8'h04);
        wr(8'h09, 1, 8'h00, 8'h00, ok);
        chk("R8 follows live", {7'd0, lol_o}, 8'd0);
        // R7 clear sticky lol with 1 then 0
        wr(8'h09, 1, 8'h40, 8'h00, ok);
        wr(8'h09, 1, 8'h00, 8'h00, ok);
        rd_chk("R7 lol cleared", 8'h04);

        // R6 full status
        los_raw = 1; lol_live = 1; m_lol = 1;
        meas_done = 1; @(negedge clk); meas_done = 0; m_meas = 1;
        rd_chk("R6 status all", 8'h04);
        lol_live = 0;
        wr(8'h09, 1, 8'h08, 8'h00, ok);
        wr(8'h09, 1, 8'h00, 8'h00, ok);
        rd_chk("R7 meas cleared", 8'h04);

        // R7 acquisition pulse
        acq_cnt = 0;
        wr(8'h09, 1, 8'h20, 8'h00, ok);
        wr(8'h09, 1, 8'h00, 8'h00, ok);
        wr(8'h09, 1, 8'h00, 8'h00, ok);
        chk("R7 acq pulses", acq_cnt[7:0], 8'd1);

        // R9 polarity
        wr(8'h11, 1, 8'h04, 8'h00, ok);
        chk("R9 inverted", {7'd0, los_o}, 8'd0);
        los_raw = 0; @(negedge clk);
        chk("R9 inverted low", {7'd0, los_o}, 8'd1);
        wr(8'h11, 1, 8'h00, 8'h00, ok);
        chk("R9 normal", {7'd0, los_o}, 8'd0);

        // R5 unmapped and read-only addresses
        wr(8'h30, 1, 8'hAB, 8'h00, ok);
        rd_chk("R5 unmapped", 8'h30);
        wr(8'h05, 2, 8'hFF, 8'hFF, ok);
        rd_chk("R5 read-only kept", 8'h05);
        rd_chk("R5 C not readable", 8'h11);

        // random phase
        acq_cnt = 0; m_acq = 0;
        m_lol = 1; lol_live = 1; @(negedge clk); lol_live = 0;
        for (int k = 0; k < 20; k++) begin
            int unsigned r;
            r = $urandom;
            case (r % 7)
                0: sub = 8'h08; 1: sub = 8'h09; 2: sub = 8'h11;
                3: sub = 8'h05; 4: sub = 8'h04; 5: sub = 8'h08;
                default: sub = 8'($urandom);
            endcase
            d0 = 8'($urandom); d1 = 8'($urandom);
            los_raw = r[9];
            if (r[10]) begin meas_done = 1; @(negedge clk); meas_done = 0; m_meas = 1; end
            wr(sub, r[3] ? 2 : 1, d0, d1, ok);
            chk("R2 random ack", {7'd0, ok}, 8'd1);
            case (r[6:5])
                0: rd_chk("R6 random status", 8'h04);
                1: rd_chk("R4 random A/B", 8'h05);
                2: rd_chk("R4 random B", 8'h06);
                default: rd_chk("R5 random any", 8'($urandom));
            endcase
            chk("R8 random lol", {7'd0, lol_o}, {7'd0, m_b[7] ? m_lol : 1'b0});
            chk("R9 random los", {7'd0, los_o}, {7'd0, los_raw ^ m_inv});
            chk("R4 random ctrl_a", ctrl_a_o, m_a);
        end
        chk("R7 random acq", acq_cnt[7:0], m_acq[7:0]);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule